// File: doc/BRIEF.md
# Latching Interrupt Aggregator with Polarity

The block gathers eight interrupt causes into a single interrupt line: five general-purpose input lines, a microphone-present flag, a microphone-short flag and a sequencer-busy flag. Each cause is brought into the clock domain through a synchronizer. All but the sequencer-busy flag can then be inverted, so that either the arrival or the removal of a condition counts as an event. The result sets a sticky status bit.

Software reads the status word through a one-cycle read strobe. That read returns the latched bits and clears them at the next clock edge. A bit whose cause is still active sets again at once, so the interrupt line stays asserted until the cause goes away. A mask register selects which status bits may raise the interrupt line. An output polarity bit chooses whether the line is active high or active low. The mask, inversion and polarity settings are written through a small address/data write port.

Top module: `irq_aggregator`

## Requirements
- R1: The status word has one bit per cause: bits 0 to 4 are the general-purpose inputs 0 to 4, bit 5 is the microphone-present flag, bit 6 is the microphone-short flag and bit 7 is the sequencer-busy flag.
- R2: A status bit, once set, stays set on every clock edge where no read strobe is given, whatever its cause does afterwards.
- R3: While `rd_stb` is high, `rd_data` shows the current status word in the same cycle; at the following clock edge every bit whose cause is inactive clears. While `rd_stb` is low, `rd_data` is zero.
- R4: A cause that is active in the cycle of a read keeps its status bit set after the read, so the interrupt output stays asserted while the cause persists.
- R5: The interrupt output is active exactly when some status bit is set whose mask bit is 0. A mask bit of 1 blocks that bit from the output but not from the status word.
- R6: Inversion bits 0 to 6 invert the sampled level of causes 0 to 6 before it sets the status bit, so the low level counts as the active one. Inversion bit 7 has no effect: the sequencer-busy cause is always active high.
- R7: When the polarity bit is 0 the interrupt output is high when active; when it is 1 the output is low when active and high when idle.
- R8: After reset the status word is zero, all mask bits are 1, all inversion bits are 0, the polarity bit is 0 and the interrupt output is low.
- R9: A change on a cause input first shows in the status word after the third rising clock edge that follows it (two synchronizer stages, then the status register). An inversion change acts at the next edge.
- R10: A configuration write with `cfg_we` high selects by `cfg_addr`: 0 writes the mask, 1 writes the inversion bits, 2 writes the polarity from `cfg_wdata[0]`, and 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gpio_in | input | 5 | General-purpose interrupt causes, asynchronous |
| mic_det_in | input | 1 | Microphone-present flag, asynchronous |
| mic_short_in | input | 1 | Microphone-short flag, asynchronous |
| seq_busy_in | input | 1 | Sequencer-busy flag, asynchronous |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rd_stb | input | 1 | Status read strobe, clears on the next edge |
| rd_data | output | 8 | Status word during a read, zero otherwise |
| irq_out | output | 1 | Aggregated interrupt output, programmable level |

## Verification
The assertions check on every cycle that latched bits never drop without a read, that an active cause always leaves its bit set after the edge, that a read with no active cause empties the word, that the read bus is quiet without a strobe, that a fully masked word leaves the output at its idle level, and that a write to the spare address changes no setting. Only the bench scenarios can show the three-edge input latency, that an event pulse shorter than a read interval is still caught, that inversion turns a removal into an event for causes 0 to 6 and not for cause 7, and the output polarity under mixed masks. These are checked against a cycle model in the bench that runs alongside a long random run of inputs, reads and writes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int N_GPIO      = 5;
    localparam int N_SRC       = N_GPIO + 3;
    localparam int IDX_MICDET  = N_GPIO;
    localparam int IDX_MICSHRT = N_GPIO + 1;
    localparam int IDX_SEQBUSY = N_GPIO + 2;
    localparam int CFG_AW      = 2;

    typedef logic [N_SRC-1:0] src_vec_t;

    typedef enum logic [CFG_AW-1:0] {
        CFG_MASK = 2'd0,
        CFG_INV  = 2'd1,
        CFG_POL  = 2'd2,
        CFG_RSVD = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        src_vec_t mask;
        src_vec_t inv;
        logic     pol;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mask: '1, inv: '0, pol: 1'b0};

    // Which causes may be inverted: all except the sequencer-busy flag.
    function automatic src_vec_t inv_allowed();
        src_vec_t v;
        for (int i = 0; i < N_SRC; i++) begin
            v[i] = (i != IDX_SEQBUSY);
        end
        return v;
    endfunction

    function automatic src_vec_t pack_sources(
        input logic [N_GPIO-1:0] gpio,
        input logic              det,
        input logic              shrt,
        input logic              busy
    );
        src_vec_t v;
        v[N_GPIO-1:0]  = gpio;
        v[IDX_MICDET]  = det;
        v[IDX_MICSHRT] = shrt;
        v[IDX_SEQBUSY] = busy;
        return v;
    endfunction

    function automatic src_vec_t apply_inversion(input src_vec_t lvl, input src_vec_t inv);
        return lvl ^ (inv & inv_allowed());
    endfunction

    function automatic logic any_pending(input src_vec_t st, input src_vec_t mask);
        return |(st & ~mask);
    endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

    // R9
    sync_reset_chk: assert property (@(posedge clk) rst |=> (q == '0));

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  src_vec_t          wdata,
    output cfg_t              cfg
);
    cfg_sel_e sel;
    cfg_t     cfg_q;

    assign sel = cfg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            unique case (sel)
                CFG_MASK: cfg_q.mask <= wdata;
                CFG_INV:  cfg_q.inv  <= wdata;
                CFG_POL:  cfg_q.pol  <= wdata[0];
                CFG_RSVD: ;
                default:  ;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R8
    cfg_reset_chk: assert property (@(posedge clk) rst |=> (cfg == CFG_RESET));

    // R10
    cfg_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == CFG_RSVD) |=> $stable(cfg));

    // R10
    cfg_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg));

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t cond,
    input  logic     rd_stb,
    output src_vec_t status,
    output src_vec_t rd_data
);
    src_vec_t st_q;
    src_vec_t st_keep;

    // A read empties the held bits; a live cause sets its bit regardless.
    always_comb begin
        st_keep = rd_stb ? '0 : st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_keep | cond;
    end

    assign status  = st_q;
    assign rd_data = rd_stb ? st_q : '0;

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((status & $past(status)) == $past(status)));

    // R4
    live_sets_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(cond)) == $past(cond)));

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && cond == '0) |=> (status == '0));

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> (rd_data == '0));

    // R8
    status_reset_chk: assert property (@(posedge clk) rst |=> (status == '0));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_GPIO-1:0] gpio_in,
    input  logic              mic_det_in,
    input  logic              mic_short_in,
    input  logic              seq_busy_in,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [N_SRC-1:0]  cfg_wdata,
    input  logic              rd_stb,
    output logic [N_SRC-1:0]  rd_data,
    output logic              irq_out
);
    src_vec_t raw_lvl;
    src_vec_t sync_lvl;
    src_vec_t cond;
    src_vec_t status;
    src_vec_t rd_word;
    cfg_t     cfg;
    logic     pending;

    assign raw_lvl = pack_sources(gpio_in, mic_det_in, mic_short_in, seq_busy_in);

    irq_src_sync #(
        .WIDTH  (N_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (sync_lvl)
    );

    irq_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign cond = apply_inversion(sync_lvl, cfg.inv);

    irq_status_latch u_stat (
        .clk     (clk),
        .rst     (rst),
        .cond    (cond),
        .rd_stb  (rd_stb),
        .status  (status),
        .rd_data (rd_word)
    );

    assign pending = any_pending(status, cfg.mask);
    assign irq_out = pending ^ cfg.pol;
    assign rd_data = rd_word;

    // R5
    masked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mask == '1) |-> (irq_out == cfg.pol));

    // R8
    irq_reset_chk: assert property (@(posedge clk) rst |=> !irq_out);

    // R6
    busy_no_inv_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_lvl[IDX_SEQBUSY] |-> !cond[IDX_SEQBUSY]);

endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] gpio_in;
    logic       mic_det_in, mic_short_in, seq_busy_in;
    logic       cfg_we;
    logic [1:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       rd_stb;
    logic [7:0] rd_data;
    logic       irq_out;

    int checks = 0;
    int failures = 0;

    // bench model state
    logic [7:0] m_s1, m_s2, m_st, m_mask, m_inv;
    logic       m_pol;

    always #10 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst(rst), .gpio_in(gpio_in), .mic_det_in(mic_det_in),
        .mic_short_in(mic_short_in), .seq_busy_in(seq_busy_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq_out(irq_out)
    );

    function automatic logic exp_irq(input logic [7:0] st, input logic [7:0] mk, input logic pl);
        return (|(st & ~mk)) ^ pl;
    endfunction

    function automatic logic [7:0] exp_cond(input logic [7:0] lvl, input logic [7:0] iv);
        return lvl ^ (iv & 8'h7F);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare outputs, advance model, cross posedge.
    task automatic step(input logic [7:0] src, input logic rd, input logic we,
                        input logic [1:0] a, input logic [7:0] wd, input string tag);
        logic [7:0] nst;
        @(negedge clk);
        gpio_in = src[4:0]; mic_det_in = src[5]; mic_short_in = src[6]; seq_busy_in = src[7];
        rd_stb = rd; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        #1;
        check({tag, " rd_data"}, rd_data, rd ? m_st : 8'h00);
        check({tag, " irq"}, {7'd0, irq_out}, {7'd0, exp_irq(m_st, m_mask, m_pol)});
        nst  = (rd ? 8'h00 : m_st) | exp_cond(m_s2, m_inv);
        m_st = nst;
        m_s2 = m_s1;
        m_s1 = src;
        if (we) begin
            case (a)
                2'd0: m_mask = wd;
                2'd1: m_inv  = wd;
                2'd2: m_pol  = wd[0];
                default: ;
            endcase
        end
        @(posedge clk);
    endtask

    task automatic idle(input logic [7:0] src, input int n, input string tag);
        for (int i = 0; i < n; i++) step(src, 1'b0, 1'b0, 2'd0, 8'h00, tag);
    endtask

    task automatic peek_irq(input logic exp, input string tag);
        @(negedge clk); #1;
        check(tag, {7'd0, irq_out}, {7'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; gpio_in = '0; mic_det_in = 0; mic_short_in = 0; seq_busy_in = 0;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; rd_stb = 0;
        repeat (3) @(posedge clk);
        m_s1 = 0; m_s2 = 0; m_st = 0; m_mask = 8'hFF; m_inv = 0; m_pol = 0;
        @(negedge clk); rst = 1'b0;
        #1;
        // R8 reset state at the ports
        check("R8 irq after reset", {7'd0, irq_out}, 8'h00);
        check("R8 rd_data quiet", rd_data, 8'h00);
        @(posedge clk);
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R8 status zero");
        // R8 mask all 1: a live cause cannot raise irq
        idle(8'h01, 4, "R8 masked");
        peek_irq(1'b0, "R8 masked after reset");
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R5 masked bit still in status");
        idle(8'h00, 3, "flush");
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R3 clear");

        // R10 unmask everything
        step(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R10 mask write");
        // R9 latency: gpio0 rises, status sets after third edge
        step(8'h01, 1'b0, 1'b0, 2'd0, 8'h00, "R9");
        peek_irq(1'b0, "R9 after edge 1");
        @(posedge clk);
        m_st = m_st | exp_cond(m_s2, m_inv); m_s2 = m_s1;
        peek_irq(1'b0, "R9 after edge 2");
        @(posedge clk);
        m_st = m_st | exp_cond(m_s2, m_inv); m_s2 = m_s1;
        peek_irq(1'b1, "R9 after edge 3");
        @(posedge clk);
        m_st = m_st | exp_cond(m_s2, m_inv); m_s2 = m_s1;

        // R4 read while cause persists: bit stays set, irq stays high
        step(8'h01, 1'b1, 1'b0, 2'd0, 8'h00, "R4 read live");
        peek_irq(1'b1, "R4 irq held");
        @(posedge clk);
        m_st = m_st | exp_cond(m_s2, m_inv); m_s2 = m_s1;
        step(8'h01, 1'b1, 1'b0, 2'd0, 8'h00, "R4 reread shows bit0");
        // remove cause, flush, read clears (R3)
        idle(8'h00, 3, "R3 drain");
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R3 read");
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R3 empty after read");
        peek_irq(1'b0, "R3 irq low after clear");
        @(posedge clk);

        // R2 sticky: one-cycle pulse on gpio2
        step(8'h04, 1'b0, 1'b0, 2'd0, 8'h00, "R2 pulse");
        idle(8'h00, 6, "R2 hold");
        peek_irq(1'b1, "R2 irq held without read");
        @(posedge clk);
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R2 read shows bit2");
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R2 read empty");

        // R5 mask all but bit5, pulse gpio3 then mic_det
        step(8'h00, 1'b0, 1'b1, 2'd0, 8'hDF, "R5 mask write");
        step(8'h08, 1'b0, 1'b0, 2'd0, 8'h00, "R5 pulse gpio3");
        idle(8'h00, 4, "R5 masked");
        peek_irq(1'b0, "R5 gpio3 masked");
        @(posedge clk);
        step(8'h20, 1'b0, 1'b0, 2'd0, 8'h00, "R1 R5 pulse mic_det");
        idle(8'h00, 4, "R5 unmasked");
        peek_irq(1'b1, "R5 mic_det passes");
        @(posedge clk);
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R1 status bits 3 and 5");

        // R6 inversion of mic_short: low level becomes event
        step(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R6 unmask");
        step(8'h00, 1'b0, 1'b1, 2'd1, 8'h40, "R6 inv bit6");
        idle(8'h00, 2, "R6 settle");
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R6 bit6 set by removal");
        // R6 inversion bit7 ignored
        step(8'h40, 1'b0, 1'b1, 2'd1, 8'h80, "R6 inv bit7");
        idle(8'h00, 3, "R6 settle 7");
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R6 read");
        step(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R6 bit7 not set");
        peek_irq(1'b0, "R6 no event from inv bit7");
        @(posedge clk);

        // R7 polarity inverted: idle high, active low
        step(8'h00, 1'b0, 1'b1, 2'd2, 8'h01, "R7 pol write");
        peek_irq(1'b1, "R7 idle high");
        @(posedge clk);
        step(8'h80, 1'b0, 1'b0, 2'd0, 8'h00, "R7 busy pulse");
        idle(8'h00, 3, "R7 active");
        peek_irq(1'b0, "R7 active low");
        @(posedge clk);

        // R10 spare address changes nothing
        step(8'h00, 1'b0, 1'b1, 2'd3, 8'h00, "R10 spare write");
        idle(8'h00, 2, "R10 after spare");
        peek_irq(1'b0, "R10 pol unchanged");
        @(posedge clk);

        // random run checked against the model
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] src;
            logic rd, we;
            src = ($urandom_range(0, 3) == 0) ? 8'($urandom) : m_s1;
            rd  = ($urandom_range(0, 3) == 0);
            we  = ($urandom_range(0, 15) == 0);
            step(src, rd, we, 2'($urandom), 8'($urandom), "R2 R3 R5 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule